// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block takes one memory request at a time, a read or a write aimed at a flat address, and turns it into the DRAM commands that serve it. The address is split into fields in a fixed order. Going from least to most significant bit, the fields are channel, bank, column and row. The block keeps a small table with one entry per bank. Each entry records whether the bank has a row open and, if so, which row.

From that table the sequencer picks one of three paths:
- **Row hit:** it issues only a column command.
- **Row miss:** the bank is closed, so it activates the row first.
- **Row conflict:** a different row is open, so it precharges the bank and then activates the row.

A per-bank down-counter holds off the next command to a bank until the precharge or activate-to-column delay has passed. A policy input selects plain or auto-precharging column commands. The block marks the first and last cycle of the data burst that follows each column command.

A controller drives requests with a valid/ready handshake. It presents the next request once ready returns, which happens right after the last burst cycle.

Top module: `dram_bank_seq`

## Requirements
- R1: Address bits are decoded as channel = `[CH_W-1:0]`, bank = next `BANK_W` bits, column = next `COL_W` bits, row = top `ROW_W` bits. The channel field does not take part in hit detection and is echoed on `cmd_chan` with every command.
- R2: After reset, `req_ready` is 1, `cmd` is NOP, `data_valid` and `burst_done` are 0, and every bank is closed. A request accepted in the first cycle after reset takes the row-miss path.
- R3: A request whose bank has the same row open issues only a column command, two cycles after the accept cycle.
- R4: A request to a closed bank issues ACT with the row on `cmd_addr`, then the column command exactly `T_RCD` cycles after the ACT.
- R5: A request to a bank with a different row open issues PRE two cycles after the accept cycle with `cmd_addr` 0, then ACT `T_RP` cycles after the PRE, then the column command `T_RCD` cycles after the ACT.
- R6: `burst_start` pulses `T_CL` cycles after the column command. `data_valid` is high for `T_BURST` consecutive cycles starting there. `burst_done` pulses in the last of those cycles.
- R7: `req_ready` is low from the cycle after acceptance through the last burst cycle and high again in the next cycle. Requests presented while it is low are ignored and produce no commands.
- R8: The column command is RD (write=0) or WR (write=1). When `req_autopre` is 1 it is RDA or WRA instead. The column appears zero-extended on `cmd_addr`.
- R9: After an auto-precharging command the bank is closed, so the next request to it is a row miss. Its ACT comes no earlier than `T_RP`+1 cycles after that request's `burst_done` cycle.
- R10: `cmd` is one-hot with bit 0 NOP, 1 ACT, 2 PRE, 3 RD, 4 RDA, 5 WR, 6 WRA. During NOP, `cmd_bank`, `cmd_addr` and `cmd_chan` are 0.
- R11: Banks are tracked independently: opening a row in one bank leaves another bank's open row in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | CH_W+BANK_W+COL_W+ROW_W | Flat request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Use auto-precharging column command |
| cmd | output | 7 | One-hot DRAM command |
| cmd_chan | output | CH_W | Channel of the command |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | max(ROW_W,COL_W) | Row (ACT) or column (RD/WR) |
| burst_start | output | 1 | First data-burst cycle |
| data_valid | output | 1 | Data bus occupied by the burst |
| burst_done | output | 1 | Last data-burst cycle |

## Verification
Every result is tied to a cycle counted from the accept cycle:
- the first command appears two cycles after acceptance;
- ACT appears either at that point or when the bank's precharge window closes, whichever is later;
- the column command follows ACT by `T_RCD` cycles;
- the burst spans cycles `T_CL` through `T_CL+T_BURST-1` after the column command.

For each request the driver computes the exact cycle of every command and burst marker from its own model of the banks and queues them. The monitor samples on the falling edge and compares each observed event, cycle number included, with the head of the queue. On every cycle it also compares `req_ready` and `data_valid` with the windows the driver predicted.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  localparam int CMD_N = 7;
  localparam int C_NOP = 0;
  localparam int C_ACT = 1;
  localparam int C_PRE = 2;
  localparam int C_RD  = 3;
  localparam int C_RDA = 4;
  localparam int C_WR  = 5;
  localparam int C_WRA = 6;

  typedef logic [CMD_N-1:0] cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_DATA
  } seq_state_t;

  function automatic cmd_t cmd_bit(input int idx);
    cmd_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
  parameter int CH_W   = 1,
  parameter int BANK_W = 2,
  parameter int COL_W  = 4,
  parameter int ROW_W  = 6
) (
  input  logic [CH_W+BANK_W+COL_W+ROW_W-1:0] addr,
  output logic [CH_W-1:0]                    ch,
  output logic [BANK_W-1:0]                  bank,
  output logic [COL_W-1:0]                   col,
  output logic [ROW_W-1:0]                   row
);
  localparam int BANK_LSB = CH_W;
  localparam int COL_LSB  = BANK_LSB + BANK_W;
  localparam int ROW_LSB  = COL_LSB + COL_W;

  // Field order is fixed, low to high: channel, bank, column, row (R1)
  assign ch   = addr[0 +: CH_W];
  assign bank = addr[BANK_LSB +: BANK_W];
  assign col  = addr[COL_LSB +: COL_W];
  assign row  = addr[ROW_LSB +: ROW_W];
endmodule

// File: rtl/dram_bank_table.sv
module dram_bank_table #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 6,
  parameter int T_RP   = 3,
  parameter int T_RCD  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] lk_bank,
  output logic              lk_open,
  output logic [ROW_W-1:0]  lk_row,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row,
  output logic              gate_ok,
  input  logic              act_en,
  input  logic              pre_en,
  input  logic              ap_close,
  input  logic              ap_charge
);
  localparam int NBANK = 1 << BANK_W;
  localparam int TMAX  = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int TW    = $clog2(TMAX + 1);

  logic [NBANK-1:0]            open_v;
  logic [NBANK-1:0][ROW_W-1:0] row_v;
  logic [NBANK-1:0]            tz_v;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             open_r;
    logic [ROW_W-1:0] row_r;
    logic [TW-1:0]    tmr_r;
    logic             sel;

    assign sel = (upd_bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        open_r <= 1'b0;
        row_r  <= '0;
        tmr_r  <= '0;
      end else begin
        if (sel && act_en) begin
          open_r <= 1'b1;
          row_r  <= upd_row;
        end else if (sel && (pre_en || ap_close)) begin
          open_r <= 1'b0;
        end
        if (sel && (pre_en || ap_charge))
          tmr_r <= TW'(T_RP - 1);
        else if (sel && act_en)
          tmr_r <= TW'(T_RCD - 1);
        else if (tmr_r != '0)
          tmr_r <= tmr_r - 1'b1;
      end
    end

    assign open_v[b] = open_r;
    assign row_v[b]  = row_r;
    assign tz_v[b]   = (tmr_r == '0);
  end

  assign lk_open = open_v[lk_bank];
  assign lk_row  = row_v[lk_bank];
  assign gate_ok = tz_v[upd_bank];

  // R4: only a closed bank may be activated
  p_act_on_closed_r4: assert property (@(posedge clk) disable iff (rst)
    act_en |-> !open_v[upd_bank]);
  // R5: an explicit precharge only targets a bank that holds a row
  p_pre_on_open_r5: assert property (@(posedge clk) disable iff (rst)
    pre_en |-> open_v[upd_bank]);
  // R9: by the end of an auto-precharged burst the bank is already closed
  p_ap_closed_r9: assert property (@(posedge clk) disable iff (rst)
    ap_charge |-> !open_v[upd_bank]);
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int CH_W    = 1,
  parameter int BANK_W  = 2,
  parameter int COL_W   = 4,
  parameter int ROW_W   = 6,
  parameter int CMD_AW  = 6,
  parameter int T_CL    = 4,
  parameter int T_BURST = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_autopre,
  input  logic [CH_W-1:0]   dec_ch,
  input  logic [COL_W-1:0]  dec_col,
  input  logic [ROW_W-1:0]  dec_row,
  input  logic              lk_open,
  input  logic [ROW_W-1:0]  lk_row,
  input  logic              gate_ok,
  output logic [BANK_W-1:0] cur_bank,
  output logic [ROW_W-1:0]  cur_row,
  input  logic [BANK_W-1:0] dec_bank,
  output logic              act_en,
  output logic              pre_en,
  output logic              ap_close,
  output logic              ap_charge,
  output cmd_t              cmd,
  output logic [CH_W-1:0]   cmd_chan,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [CMD_AW-1:0] cmd_addr,
  output logic              burst_start,
  output logic              data_valid,
  output logic              burst_done
);
  localparam int DW = $clog2(T_CL + T_BURST + 1);

  seq_state_t        state_q;
  logic [CH_W-1:0]   ch_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              wr_q, ap_q;
  logic [DW-1:0]     dcnt_q;
  cmd_t              cmd_q, col_cmd;
  logic [CH_W-1:0]   cmd_ch_q;
  logic [BANK_W-1:0] cmd_bank_q;
  logic [CMD_AW-1:0] cmd_addr_q;

  always_comb begin
    if (wr_q) col_cmd = ap_q ? cmd_bit(C_WRA) : cmd_bit(C_WR);
    else      col_cmd = ap_q ? cmd_bit(C_RDA) : cmd_bit(C_RD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ch_q       <= '0;
      bank_q     <= '0;
      row_q      <= '0;
      col_q      <= '0;
      wr_q       <= 1'b0;
      ap_q       <= 1'b0;
      dcnt_q     <= '0;
      cmd_q      <= cmd_bit(C_NOP);
      cmd_ch_q   <= '0;
      cmd_bank_q <= '0;
      cmd_addr_q <= '0;
    end else begin
      cmd_q      <= cmd_bit(C_NOP);
      cmd_ch_q   <= '0;
      cmd_bank_q <= '0;
      cmd_addr_q <= '0;
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          ch_q   <= dec_ch;
          bank_q <= dec_bank;
          row_q  <= dec_row;
          col_q  <= dec_col;
          wr_q   <= req_write;
          ap_q   <= req_autopre;
          if (!lk_open)              state_q <= ST_ACT;
          else if (lk_row == dec_row) state_q <= ST_COL;
          else                       state_q <= ST_PRE;
        end
        ST_PRE: if (gate_ok) begin
          cmd_q      <= cmd_bit(C_PRE);
          cmd_ch_q   <= ch_q;
          cmd_bank_q <= bank_q;
          state_q    <= ST_ACT;
        end
        ST_ACT: if (gate_ok) begin
          cmd_q      <= cmd_bit(C_ACT);
          cmd_ch_q   <= ch_q;
          cmd_bank_q <= bank_q;
          cmd_addr_q <= CMD_AW'(row_q);
          state_q    <= ST_COL;
        end
        ST_COL: if (gate_ok) begin
          cmd_q      <= col_cmd;
          cmd_ch_q   <= ch_q;
          cmd_bank_q <= bank_q;
          cmd_addr_q <= CMD_AW'(col_q);
          dcnt_q     <= DW'(T_CL + T_BURST - 1);
          state_q    <= ST_DATA;
        end
        ST_DATA: begin
          if (dcnt_q == '0) state_q <= ST_IDLE;
          else              dcnt_q  <= dcnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cur_bank    = bank_q;
  assign cur_row     = row_q;
  assign pre_en      = (state_q == ST_PRE) && gate_ok;
  assign act_en      = (state_q == ST_ACT) && gate_ok;
  assign ap_close    = (state_q == ST_COL) && gate_ok && ap_q;
  assign ap_charge   = (state_q == ST_DATA) && (dcnt_q == '0) && ap_q;

  assign req_ready   = (state_q == ST_IDLE);
  assign data_valid  = (state_q == ST_DATA) && (dcnt_q < DW'(T_BURST));
  assign burst_start = (state_q == ST_DATA) && (dcnt_q == DW'(T_BURST - 1));
  assign burst_done  = (state_q == ST_DATA) && (dcnt_q == '0);

  assign cmd      = cmd_q;
  assign cmd_chan = cmd_ch_q;
  assign cmd_bank = cmd_bank_q;
  assign cmd_addr = cmd_addr_q;

  p_cmd_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $countones(cmd_q) == 1);
  p_nop_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_q[C_NOP] |-> (cmd_bank_q == '0 && cmd_addr_q == '0 && cmd_ch_q == '0));
  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  p_done_frees_r7: assert property (@(posedge clk) disable iff (rst)
    burst_done |=> req_ready);
  p_start_in_burst_r6: assert property (@(posedge clk) disable iff (rst)
    burst_start |-> data_valid);
  p_col_before_data_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_q[C_RD] || cmd_q[C_RDA] || cmd_q[C_WR] || cmd_q[C_WRA]) |-> !data_valid);
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dram_seq_pkg::*;
#(
  parameter int CH_W    = 1,
  parameter int BANK_W  = 2,
  parameter int COL_W   = 4,
  parameter int ROW_W   = 6,
  parameter int T_RP    = 3,
  parameter int T_RCD   = 3,
  parameter int T_CL    = 4,
  parameter int T_BURST = 4
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       req_valid,
  output logic                                       req_ready,
  input  logic [CH_W+BANK_W+COL_W+ROW_W-1:0]         req_addr,
  input  logic                                       req_write,
  input  logic                                       req_autopre,
  output logic [CMD_N-1:0]                           cmd,
  output logic [CH_W-1:0]                            cmd_chan,
  output logic [BANK_W-1:0]                          cmd_bank,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] cmd_addr,
  output logic                                       burst_start,
  output logic                                       data_valid,
  output logic                                       burst_done
);
  localparam int CMD_AW = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [CH_W-1:0]   dec_ch;
  logic [BANK_W-1:0] dec_bank, cur_bank;
  logic [COL_W-1:0]  dec_col;
  logic [ROW_W-1:0]  dec_row, lk_row, cur_row;
  logic              lk_open, gate_ok;
  logic              act_en, pre_en, ap_close, ap_charge;

  dram_addr_split #(
    .CH_W(CH_W), .BANK_W(BANK_W), .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_split (
    .addr(req_addr), .ch(dec_ch), .bank(dec_bank), .col(dec_col), .row(dec_row)
  );

  dram_bank_table #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .T_RP(T_RP), .T_RCD(T_RCD)
  ) u_table (
    .clk(clk), .rst(rst),
    .lk_bank(dec_bank), .lk_open(lk_open), .lk_row(lk_row),
    .upd_bank(cur_bank), .upd_row(cur_row), .gate_ok(gate_ok),
    .act_en(act_en), .pre_en(pre_en), .ap_close(ap_close), .ap_charge(ap_charge)
  );

  dram_seq_ctrl #(
    .CH_W(CH_W), .BANK_W(BANK_W), .COL_W(COL_W), .ROW_W(ROW_W),
    .CMD_AW(CMD_AW), .T_CL(T_CL), .T_BURST(T_BURST)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_autopre(req_autopre),
    .dec_ch(dec_ch), .dec_col(dec_col), .dec_row(dec_row),
    .lk_open(lk_open), .lk_row(lk_row), .gate_ok(gate_ok),
    .cur_bank(cur_bank), .cur_row(cur_row), .dec_bank(dec_bank),
    .act_en(act_en), .pre_en(pre_en), .ap_close(ap_close), .ap_charge(ap_charge),
    .cmd(cmd), .cmd_chan(cmd_chan), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .burst_start(burst_start), .data_valid(data_valid), .burst_done(burst_done)
  );
endmodule

// File: tb/sim_dram_bank_seq.sv
module sim_dram_bank_seq;
  import dram_seq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int CH_W = 1, BANK_W = 2, COL_W = 4, ROW_W = 6;
  localparam int T_RP = 3, T_RCD = 3, T_CL = 4, T_BURST = 4;
  localparam int AW = CH_W + BANK_W + COL_W + ROW_W;
  localparam int CAW = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int NB = 1 << BANK_W;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, burst_start, data_valid, burst_done;
  logic [CMD_N-1:0] cmd;
  logic [CH_W-1:0] cmd_chan;
  logic [BANK_W-1:0] cmd_bank;
  logic [CAW-1:0] cmd_addr;

  dram_bank_seq #(
    .CH_W(CH_W), .BANK_W(BANK_W), .COL_W(COL_W), .ROW_W(ROW_W),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_CL(T_CL), .T_BURST(T_BURST)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_autopre(req_autopre),
    .cmd(cmd), .cmd_chan(cmd_chan), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .burst_start(burst_start), .data_valid(data_valid), .burst_done(burst_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    cmd_t  c;
    int    bank;
    int    addr;
    int    ch;
    bit    st;
    bit    dn;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int n_chk = 0, n_bad = 0;
  bit started = 0;
  bit m_open[NB];
  int m_row[NB];
  int m_act_ok[NB];
  int lo_from = -1, lo_to = -2, dv_from = -1, dv_to = -2;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, expv);
    end
  endtask

  // Monitor: compares each observed event with the head of the scoreboard
  always @(negedge clk) begin
    if (started && !rst) begin
      check(req_ready == !(cyc >= lo_from && cyc <= lo_to), "R7", "req_ready",
            int'(req_ready), int'(!(cyc >= lo_from && cyc <= lo_to)));
      check(data_valid == (cyc >= dv_from && cyc <= dv_to), "R6", "data_valid",
            int'(data_valid), int'(cyc >= dv_from && cyc <= dv_to));
      if (!cmd[C_NOP] || burst_start || burst_done) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R7", "unexpected event cmd", int'(cmd), 1);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(cyc == e.at, e.tag, "event cycle", cyc, e.at);
          check(cmd == e.c && int'(cmd_bank) == e.bank && int'(cmd_addr) == e.addr &&
                int'(cmd_chan) == e.ch && burst_start == e.st && burst_done == e.dn,
                e.tag, "cmd/bank/addr/chan/start/done",
                (int'(cmd) << 16) | (int'(cmd_bank) << 12) | (int'(cmd_addr) << 2) |
                (int'(burst_start) << 1) | int'(burst_done),
                (int'(e.c) << 16) | (e.bank << 12) | (e.addr << 2) |
                (int'(e.st) << 1) | int'(e.dn));
        end
      end
    end
  end

  task automatic push(input int at, input cmd_t c, input int bank, input int addr,
                      input int ch, input bit st, input bit dn, input string tag);
    exp_t e;
    e.at = at; e.c = c; e.bank = bank; e.addr = addr; e.ch = ch;
    e.st = st; e.dn = dn; e.tag = tag;
    sbq.push_back(e);
  endtask

  // Driver: presents one request, predicts every event and its cycle
  task automatic send(input int ch, input int bank, input int row, input int col,
                      input bit wr, input bit ap, input int gap, input string tag);
    int a, c, act;
    cmd_t cc;
    repeat (gap) @(negedge clk);
    a = cyc;
    req_valid   = 1'b1;
    req_addr    = AW'((row << (CH_W + BANK_W + COL_W)) | (col << (CH_W + BANK_W)) |
                      (bank << CH_W) | ch);
    req_write   = wr;
    req_autopre = ap;
    cc = wr ? (ap ? cmd_bit(C_WRA) : cmd_bit(C_WR)) : (ap ? cmd_bit(C_RDA) : cmd_bit(C_RD));
    if (m_open[bank] && m_row[bank] == row) begin
      c = a + 2;                                       // R3 hit
    end else if (m_open[bank]) begin
      push(a + 2, cmd_bit(C_PRE), bank, 0, ch, 0, 0, {tag, " R5 PRE"});
      act = a + 2 + T_RP;
      push(act, cmd_bit(C_ACT), bank, row, ch, 0, 0, {tag, " R5 ACT"});
      c = act + T_RCD;
    end else begin
      act = (a + 2 > m_act_ok[bank]) ? a + 2 : m_act_ok[bank];
      push(act, cmd_bit(C_ACT), bank, row, ch, 0, 0, {tag, " R4/R9 ACT"});
      c = act + T_RCD;
    end
    push(c, cc, bank, col, ch, 0, 0, {tag, " R3/R8 column"});
    push(c + T_CL, cmd_bit(C_NOP), 0, 0, 0, 1, 0, {tag, " R6 start"});
    push(c + T_CL + T_BURST - 1, cmd_bit(C_NOP), 0, 0, 0, 0, 1, {tag, " R6 done"});
    if (ap) begin
      m_open[bank]   = 0;
      m_act_ok[bank] = c + T_CL + T_BURST - 1 + T_RP + 1;
    end else begin
      m_open[bank] = 1;
      m_row[bank]  = row;
    end
    lo_from = a + 1;
    lo_to   = c + T_CL + T_BURST - 1;
    dv_from = c + T_CL;
    dv_to   = c + T_CL + T_BURST - 1;
    @(negedge clk);
    // R7: requests offered while busy must be ignored
    req_addr  = ~req_addr;
    req_write = ~wr;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    while (cyc < lo_to + 1) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin
      m_open[i] = 0; m_row[i] = 0; m_act_ok[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R2 reset state
    check(req_ready == 1'b1, "R2", "ready in reset", int'(req_ready), 1);
    check(cmd == cmd_bit(C_NOP), "R2", "cmd in reset", int'(cmd), int'(cmd_bit(C_NOP)));
    check(!data_valid && !burst_done && !burst_start, "R2", "burst flags in reset",
          int'(data_valid), 0);
    rst = 1'b0;
    started = 1;
    send(0, 1, 5, 3, 0, 0, 0, "R2 first-cycle miss");
    send(1, 1, 5, 7, 0, 0, 0, "R1 channel bit set, hit");
    send(0, 1, 9, 2, 1, 0, 0, "R5 conflict write");
    send(1, 2, 9, 1, 1, 0, 1, "R11 other bank miss");
    send(0, 1, 9, 4, 0, 0, 0, "R11 first bank still open");
    send(0, 1, 9, 5, 0, 1, 0, "R8 read autopre");
    send(0, 1, 9, 6, 0, 0, 0, "R9 closed after autopre");
    send(1, 2, 9, 0, 1, 1, 0, "R8 write autopre");
    send(0, 2, 3, 8, 0, 0, 5, "R9 timer expired");
    send(1, 3, 63, 15, 0, 0, 0, "R1 max fields");
    send(0, 3, 0, 0, 1, 0, 0, "R5 conflict row 0");
    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R6", "missing events", sbq.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R7 watchdog expired: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule